// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side master for a 16-bit successive-approximation converter with a three-wire serial link: a chip select, a serial clock and one data line. When a start request arrives it drives chip select low and generates the serial clock by dividing the system clock. It ignores the converter's sampling window and checks the low null bit that precedes the data. It then assembles the result, most significant bit first, on rising serial clock edges. The converter changes its data line on falling edges.

In checking mode the controller keeps clocking after bit 0 and collects the mirrored copy of bits 1 to 15, which the converter sends least significant bit first. It compares that copy with the first one to flag a link error. In short mode chip select rises straight after bit 0. In either mode the finished word appears with a one-cycle valid strobe. The word is plain unsigned binary.

Top module: `adc_serial_reader`

## Requirements
- R1: A start pulse accepted while idle drives cs_n low on the next system clock edge. A start pulse that arrives while a frame is in progress is ignored: it neither restarts nor extends the frame.
- R2: sclk is high whenever cs_n is high. During a frame each low phase and each high phase of sclk lasts div_n+1 system clocks, so one serial period is 2*(div_n+1) system clocks. The first edge after cs_n falls is a falling edge.
- R3: sdata is sampled on rising sclk edges. Bits arriving in serial periods 1 to 5, the sampling window, have no effect on result.
- R4: The bit sampled in serial period 6 is the null bit. If it is high, frame_err is set.
- R5: Periods 7 to 22 carry the word most significant bit first. result takes this word unchanged, as unsigned binary, in bit order result[15] down to result[0].
- R6: With check_en low at start, the frame has exactly 22 rising sclk edges, and cs_n rises together with the edge that samples bit 0.
- R7: With check_en high at start, the frame has exactly 37 rising sclk edges. Periods 23 to 37 carry bits 1 through 15 in that order. A mismatch of any of them against the first copy sets mirror_err, and result still holds the first copy.
- R8: valid is high for exactly one system clock per frame, in the same cycle that cs_n returns high, with result already updated.
- R9: frame_err and mirror_err stay set after the frame ends and are cleared only when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion frame |
| check_en | input | 1 | Capture and compare the mirrored copy (latched at start) |
| div_n | input | 8 | Half-period of sclk minus one, in system clocks (latched at start) |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| result | output | 16 | Last converted word, unsigned |
| valid | output | 1 | One-cycle strobe with a new result |
| frame_err | output | 1 | Null bit was high |
| mirror_err | output | 1 | Mirrored copy disagreed with the first copy |

## Verification
The bench builds the block with its defaults: a 16-bit word, a 5-period sampling window and an 8-bit divider field. It drives div_n from 0 to 3. A divider of 0 is the tightest case, where a rising edge follows the converter's data change by a single system clock. Together with both modes, a forced-high null bit and single flipped mirror bits at each end of the copy, this makes every frame length and both error paths observable at the ports. The bench's converter model drives ones during the sampling window, so any leak of those bits into the result shows up.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_n,
  output logic             sclk,
  output logic             rise_tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             hit;

  assign hit = run && (cnt_q == half_n);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (hit) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
    end
  end

  assign sclk      = sclk_q;
  assign rise_tick = hit && !sclk_q;
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SAMPLE_CLKS = 5,
  parameter int DIV_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             check_en,
  input  logic [DIV_W-1:0] div_n,
  input  logic             rise_tick,
  output logic             run,
  output logic             cs_n,
  output logic [DIV_W-1:0] half_n,
  output logic             mode_chk,
  output logic             start_acc,
  output logic             null_stb,
  output logic             data_stb,
  output logic             mirror_stb,
  output logic             done_stb
);
  localparam int NULL_K  = SAMPLE_CLKS + 1;
  localparam int FIRST_D = NULL_K + 1;
  localparam int LAST_D  = NULL_K + DATA_W;
  localparam int FIRST_M = LAST_D + 1;
  localparam int LAST_M  = LAST_D + DATA_W - 1;
  localparam int CNT_W   = $clog2(LAST_M + 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] k;
  logic [CNT_W-1:0] last_k;

  assign k         = period_q + CNT_W'(1);
  assign last_k    = mode_chk ? CNT_W'(LAST_M) : CNT_W'(LAST_D);
  assign run       = (state_q == ST_RUN);
  assign start_acc = start && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      period_q <= '0;
      mode_chk <= 1'b0;
      half_n   <= '0;
      cs_n     <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_acc) begin
            state_q  <= ST_RUN;
            period_q <= '0;
            mode_chk <= check_en;
            half_n   <= div_n;
            cs_n     <= 1'b0;
          end
        end
        default: begin
          if (rise_tick) begin
            period_q <= k;
            if (k == last_k) begin
              state_q <= ST_IDLE;
              cs_n    <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign null_stb   = rise_tick && (k == CNT_W'(NULL_K));
  assign data_stb   = rise_tick && (k >= CNT_W'(FIRST_D)) && (k <= CNT_W'(LAST_D));
  assign mirror_stb = rise_tick && mode_chk && (k >= CNT_W'(FIRST_M)) && (k <= CNT_W'(LAST_M));
  assign done_stb   = rise_tick && (k == last_k);
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdata,
  input  logic              start_acc,
  input  logic              null_stb,
  input  logic              data_stb,
  input  logic              mirror_stb,
  input  logic              done_stb,
  input  logic              mode_chk,
  output logic [DATA_W-1:0] result,
  output logic              valid,
  output logic              frame_err,
  output logic              mirror_err
);
  logic [DATA_W-1:0] data_q, data_nx;
  logic [DATA_W-2:0] mir_q, mir_nx;

  assign data_nx = data_stb ? {data_q[DATA_W-2:0], sdata} : data_q;
  assign mir_nx  = mirror_stb ? {sdata, mir_q[DATA_W-2:1]} : mir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q     <= '0;
      mir_q      <= '0;
      result     <= '0;
      valid      <= 1'b0;
      frame_err  <= 1'b0;
      mirror_err <= 1'b0;
    end else begin
      data_q <= data_nx;
      mir_q  <= mir_nx;
      valid  <= done_stb;
      if (done_stb) result <= data_nx;
      if (start_acc) begin
        frame_err  <= 1'b0;
        mirror_err <= 1'b0;
      end else begin
        if (null_stb && sdata) frame_err <= 1'b1;
        if (done_stb && mode_chk && (mir_nx != data_nx[DATA_W-1:1])) mirror_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int DATA_W      = 16,
  parameter int SAMPLE_CLKS = 5,
  parameter int DIV_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              check_en,
  input  logic [DIV_W-1:0]  div_n,
  input  logic              sdata,
  output logic              cs_n,
  output logic              sclk,
  output logic [DATA_W-1:0] result,
  output logic              valid,
  output logic              frame_err,
  output logic              mirror_err
);
  logic             run, rise_tick, mode_chk, start_acc;
  logic             null_stb, data_stb, mirror_stb, done_stb;
  logic [DIV_W-1:0] half_n;

  adc_rd_seq #(
    .DATA_W(DATA_W), .SAMPLE_CLKS(SAMPLE_CLKS), .DIV_W(DIV_W)
  ) seq_i (
    .clk(clk), .rst(rst), .start(start), .check_en(check_en), .div_n(div_n),
    .rise_tick(rise_tick), .run(run), .cs_n(cs_n), .half_n(half_n),
    .mode_chk(mode_chk), .start_acc(start_acc), .null_stb(null_stb),
    .data_stb(data_stb), .mirror_stb(mirror_stb), .done_stb(done_stb)
  );

  adc_rd_sclk_gen #(.DIV_W(DIV_W)) sclk_i (
    .clk(clk), .rst(rst), .run(run), .half_n(half_n),
    .sclk(sclk), .rise_tick(rise_tick)
  );

  adc_rd_capture #(.DATA_W(DATA_W)) cap_i (
    .clk(clk), .rst(rst), .sdata(sdata), .start_acc(start_acc),
    .null_stb(null_stb), .data_stb(data_stb), .mirror_stb(mirror_stb),
    .done_stb(done_stb), .mode_chk(mode_chk), .result(result),
    .valid(valid), .frame_err(frame_err), .mirror_err(mirror_err)
  );
endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic cs_n,
  input logic sclk,
  input logic valid,
  input logic frame_err,
  input logic mirror_err
);
  p_cs_start_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(start));

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);

  p_null_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_err) |-> !cs_n);

  p_mirror_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mirror_err) |-> valid);

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  p_valid_cs_r8: assert property (@(posedge clk) disable iff (rst)
    valid |-> $rose(cs_n));

  p_frame_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_err) |-> $past(start));

  p_mirror_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(mirror_err) |-> $past(start));
endmodule

bind adc_serial_reader adc_serial_reader_chk chk_i (
  .clk(clk), .rst(rst), .start(start), .cs_n(cs_n), .sclk(sclk),
  .valid(valid), .frame_err(frame_err), .mirror_err(mirror_err)
);

// File: tb/adc_serial_reader_tb_top.sv
module adc_serial_reader_tb_top;
  typedef struct packed {
    logic [15:0] word;
    logic [7:0]  n;
    logic        chk;
    logic        bad;
    logic [4:0]  flip;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [0:NV-1] = '{
    '{16'hA5C3, 8'd0, 1'b0, 1'b0, 5'd0},
    '{16'h0000, 8'd1, 1'b1, 1'b0, 5'd0},
    '{16'hFFFF, 8'd2, 1'b1, 1'b0, 5'd0},
    '{16'h8001, 8'd0, 1'b1, 1'b0, 5'd1},
    '{16'h1234, 8'd3, 1'b0, 1'b1, 5'd0},
    '{16'h7FFE, 8'd0, 1'b1, 1'b1, 5'd15},
    '{16'hC00F, 8'd1, 1'b0, 1'b0, 5'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        check_en = 1'b0;
  logic [7:0]  div_n = 8'd0;
  logic        sdata = 1'b1;
  logic        cs_n, sclk, valid, frame_err, mirror_err;
  logic [15:0] result;

  int total = 0;
  int fails = 0;

  logic [15:0] m_word = '0;
  logic        m_bad = 1'b0;
  logic [4:0]  m_flip = '0;
  int fcnt = 0, rises = 0, lowcnt = 0, last_low = 0, vcount = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;

  always #5 clk = ~clk;

  adc_serial_reader dut_i (
    .clk(clk), .rst(rst), .start(start), .check_en(check_en), .div_n(div_n),
    .sdata(sdata), .cs_n(cs_n), .sclk(sclk), .result(result), .valid(valid),
    .frame_err(frame_err), .mirror_err(mirror_err)
  );

  function automatic logic model_bit(input int k);
    if (k <= 5) return 1'b1;
    if (k == 6) return m_bad;
    if (k <= 22) return m_word[22-k];
    if (k <= 37) return m_word[k-22] ^ (int'(m_flip) == k-22);
    return 1'b1;
  endfunction

  // converter model, evaluated away from the active edge
  always @(negedge clk) begin
    if (prev_cs && !cs_n) begin
      fcnt = 0; rises = 0; lowcnt = 0; sdata = 1'b1;
    end
    if (!cs_n && prev_sclk && !sclk) begin
      fcnt = fcnt + 1;
      sdata = model_bit(fcnt);
    end
    if (!sclk) lowcnt = lowcnt + 1;
    if (!prev_sclk && sclk) begin
      rises = rises + 1; last_low = lowcnt; lowcnt = 0;
    end
    if (valid) vcount = vcount + 1;
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 5000; i++) begin
      if (valid) return;
      @(negedge clk);
    end
    total++; fails++;
    $display("FAIL R8 valid timeout actual=0 expected=1");
    finish_run();
  endtask

  task automatic kick(input vec_t v);
    m_word = v.word; m_bad = v.bad; m_flip = v.flip;
    @(negedge clk);
    div_n = v.n; check_en = v.chk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset cs_n", 32'(cs_n), 32'd1);
    chk("R2 reset sclk", 32'(sclk), 32'd1);
    chk("R8 reset valid", 32'(valid), 32'd0);
    chk("R9 reset errors", {30'd0, frame_err, mirror_err}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vcount = 0;
      kick(VECS[i]);
      chk("R1 cs_n low after start", 32'(cs_n), 32'd0);
      wait_valid();
      chk("R5 R3 result", 32'(result), 32'(VECS[i].word));
      chk("R8 cs_n high with valid", 32'(cs_n), 32'd1);
      chk("R4 frame_err", 32'(frame_err), 32'(VECS[i].bad));
      chk("R7 mirror_err", 32'(mirror_err), 32'(VECS[i].chk && VECS[i].flip != 0));
      @(negedge clk);
      chk("R8 valid one cycle", 32'(valid), 32'd0);
      chk("R8 valid count", 32'(vcount), 32'd1);
      chk(VECS[i].chk ? "R7 rising edges" : "R6 rising edges", 32'(rises), VECS[i].chk ? 32'd37 : 32'd22);
      chk("R2 half period", 32'(last_low), 32'(VECS[i].n) + 32'd1);
      chk("R2 sclk idle", 32'(sclk), 32'd1);
      repeat (3) @(negedge clk);
    end

    // R1: second start in mid-frame is ignored
    vcount = 0;
    kick('{16'h3C3C, 8'd1, 1'b0, 1'b0, 5'd0});
    repeat (30) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_valid();
    chk("R1 result after ignored start", 32'(result), 32'h3C3C);
    repeat (10) @(negedge clk);
    chk("R1 single frame edges", 32'(rises), 32'd22);
    chk("R1 single valid", 32'(vcount), 32'd1);
    chk("R1 stays idle", 32'(cs_n), 32'd1);

    // R9: error flags hold, then clear on next accepted start
    kick('{16'h0F0F, 8'd0, 1'b1, 1'b1, 5'd8});
    wait_valid();
    repeat (25) @(negedge clk);
    chk("R9 frame_err held", 32'(frame_err), 32'd1);
    chk("R9 mirror_err held", 32'(mirror_err), 32'd1);
    kick('{16'h0F0F, 8'd0, 1'b0, 1'b0, 5'd0});
    chk("R9 frame_err cleared", 32'(frame_err), 32'd0);
    chk("R9 mirror_err cleared", 32'(mirror_err), 32'd0);
    wait_valid();
    chk("R5 result clean", 32'(result), 32'h0F0F);
    chk("R4 no frame error", 32'(frame_err), 32'd0);
    repeat (3) @(negedge clk);

    finish_run();
  end
endmodule